// File: doc/BRIEF.md
# Sized Add/Subtract Condition-Code Unit

This block does the add, subtract, compare and negate steps of an integer datapath on byte, word or long slices of 32-bit operands. In each enabled cycle it takes a source operand, a destination operand, a size code, an operation code and a marker that shows whether the destination is an address register. On the next clock edge it registers three things: the result merged into the destination, a strobe that says the result must be written back, and a new 16-bit status word. Only the low four condition bits of that status word change.

Operand fetch and address generation take place upstream. The write-back strobe and the registered status word feed the register file and the status register. Compare sets the condition bits but never writes a result. When an add or subtract targets an address register, the result is written and the status word passes through unchanged.

Top module: `addsub_ccr_unit`

## Requirements
- R1: The size code selects the slice: 00 is the low 8 bits, 01 is the low 16 bits, and 10 or 11 is all 32 bits. Result bits above the slice are copied from the destination operand.
- R2: The carry flag comes from the top of the selected slice: the carry out of an add, or the borrow of dst minus src. It never comes from bit 31 unless the slice is long.
- R3: The overflow flag rules. For add, V is set when both operands have the same sign and the result sign differs from it. For subtract and compare, V is set when the operand signs differ and the result sign differs from the destination sign.
- R4: The condition bits sit in the status word as N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. N is the top bit of the sized result, and Z is set when the sized result is all zeros.
- R5: Add or subtract with the address-register marker set still writes its result. The update strobe stays low and the status output equals the incoming status word.
- R6: Compare computes dst minus src and updates the condition bits. The write strobe stays low and the result output keeps its previous value. The address-register marker does not affect compare.
- R7: Negate computes 0 minus dst on the slice and writes it back. C is set exactly when the sized result is nonzero. V is set only when dst is the most negative value of the slice.
- R8: Carry and overflow are separate flags: a carry with no signed overflow leaves V clear.
- R9: Status bits 15:4 of the output always equal bits 15:4 of the incoming status word.
- R10: Operation codes are 00 add, 01 subtract, 10 compare and 11 negate. Outputs change one clock edge after a cycle with `en` high. In a cycle with `en` low, the next edge drops both strobes and holds the result and the status output.
- R11: A synchronous active-high reset clears the result, both strobes and the status output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Operation valid this cycle |
| op | input | 2 | Operation code (00 add, 01 sub, 10 compare, 11 negate) |
| size | input | 2 | Slice select (00 byte, 01 word, 1x long) |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| dst_is_areg | input | 1 | Destination is an address register |
| sr_in | input | 16 | Current status word |
| result_o | output | 32 | Registered result merged into the destination |
| wr_o | output | 1 | Registered result write strobe |
| upd_o | output | 1 | Registered condition-code update strobe |
| sr_o | output | 16 | Registered status word |

## Verification
The bench checks the byte and word carry cases where the 32-bit sum does not carry. A design that takes the carry from bit 31 misses those carries. It runs cases with a carry but no signed overflow, which a design that ties V to C gets wrong, and it checks sign-change overflow on add and on subtract. It also covers address-register add and subtract, where a careless design rewrites the flags, and compare with the marker set, where a design that blocks too much would lose the update. It checks negate of zero and of the most negative value, which catch a carry taken from the borrow rule or a missing overflow, and it loads status words with busy upper bits to catch a design that clears them.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int DW  = 32;
  localparam int SRW = 16;
  localparam int CCW = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_NEG = 2'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/width_sel.sv
module width_sel #(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] msb_oh
);
  localparam int LANES = DW / 8;

  // Lane 0 is always active, lane 1 for word and up, the rest only for long.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic on;
    if (l == 0) begin : g_b
      assign on = 1'b1;
    end else if (l == 1) begin : g_w
      assign on = (size != 2'b00);
    end else begin : g_l
      assign on = size[1];
    end
    assign mask[l*8 +: 8] = {8{on}};
  end

  always_comb begin
    msb_oh = '0;
    case (size)
      2'b00:   msb_oh[7]    = 1'b1;
      2'b01:   msb_oh[15]   = 1'b1;
      default: msb_oh[DW-1] = 1'b1;
    endcase
  end
endmodule

// File: rtl/sized_addsub.sv
module sized_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] msb_oh,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          a_s,
  output logic          b_s,
  output logic          r_s
);
  logic [DW:0] am, bm, raw;

  always_comb begin
    am   = {1'b0, a & mask};
    bm   = {1'b0, b & mask};
    raw  = sub ? (am - bm) : (am + bm);
    res  = raw[DW-1:0] & mask;
    // carry or borrow lands one bit above the slice's top bit
    cout = |(raw[DW:1] & msb_oh);
    a_s  = |(a & msb_oh);
    b_s  = |(b & msb_oh);
    r_s  = |(res & msb_oh);
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import addsub_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] res,
  input  logic          cout,
  input  logic          a_s,
  input  logic          b_s,
  input  logic          r_s,
  output cc_t           cc
);
  always_comb begin
    cc.n = r_s;
    cc.z = (res == '0);
    if (op == OP_ADD)
      cc.v = (a_s == b_s) && (r_s != a_s);
    else
      cc.v = (a_s != b_s) && (r_s != a_s);
    cc.c = (op == OP_NEG) ? (res != '0) : cout;
  end
endmodule

// File: rtl/addsub_ccr_unit.sv
module addsub_ccr_unit
  import addsub_pkg::*;
#(
  parameter int DW  = addsub_pkg::DW,
  parameter int SRW = addsub_pkg::SRW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [1:0]     op,
  input  logic [1:0]     size,
  input  logic [DW-1:0]  src,
  input  logic [DW-1:0]  dst,
  input  logic           dst_is_areg,
  input  logic [SRW-1:0] sr_in,
  output logic [DW-1:0]  result_o,
  output logic           wr_o,
  output logic           upd_o,
  output logic [SRW-1:0] sr_o
);
  localparam int CCW = addsub_pkg::CCW;

  op_e           op_t;
  logic [DW-1:0] mask, msb_oh, opa, opb, res, merged;
  logic          cout, a_s, b_s, r_s, is_sub, hold_cc, do_wr;
  cc_t           cc;

  assign op_t   = op_e'(op);
  assign is_sub = (op_t != OP_ADD);
  assign opa    = (op_t == OP_NEG) ? '0  : dst;
  assign opb    = (op_t == OP_NEG) ? dst : src;

  width_sel #(.DW(DW)) u_ws (.size(size), .mask(mask), .msb_oh(msb_oh));

  sized_addsub #(.DW(DW)) u_as (
    .a(opa), .b(opb), .sub(is_sub), .mask(mask), .msb_oh(msb_oh),
    .res(res), .cout(cout), .a_s(a_s), .b_s(b_s), .r_s(r_s)
  );

  flag_gen #(.DW(DW)) u_fg (
    .op(op_t), .res(res), .cout(cout), .a_s(a_s), .b_s(b_s), .r_s(r_s), .cc(cc)
  );

  assign merged  = res | (dst & ~mask);
  assign hold_cc = dst_is_areg && ((op_t == OP_ADD) || (op_t == OP_SUB));
  assign do_wr   = (op_t != OP_CMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_o     <= 1'b0;
      upd_o    <= 1'b0;
      sr_o     <= '0;
    end else if (en) begin
      if (do_wr) result_o <= merged;
      wr_o  <= do_wr;
      upd_o <= !hold_cc;
      sr_o  <= hold_cc ? sr_in : {sr_in[SRW-1:CCW], cc};
    end else begin
      wr_o  <= 1'b0;
      upd_o <= 1'b0;
    end
  end

  p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (en && op_t == OP_CMP) |=> !wr_o);

  p_areg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && dst_is_areg && (op_t == OP_ADD || op_t == OP_SUB))
      |=> (!upd_o && wr_o && sr_o == $past(sr_in)));

  p_high_bits_r9: assert property (@(posedge clk) disable iff (rst)
    en |=> (sr_o[SRW-1:CCW] == $past(sr_in[SRW-1:CCW])));

  p_neg_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (en && op_t == OP_NEG) |=> (sr_o[0] == !sr_o[2]));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!wr_o && !upd_o && $stable(result_o) && $stable(sr_o)));

  p_nz_excl_r4: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> !(sr_o[3] && sr_o[2]));
endmodule

// File: tb/sim_addsub_ccr_unit.sv
`timescale 1ns/1ps
module sim_addsub_ccr_unit;
  logic        clk = 1'b0;
  logic        rst, en, areg;
  logic [1:0]  op, size;
  logic [31:0] src, dst;
  logic [15:0] sr_in;
  logic [31:0] result_o;
  logic        wr_o, upd_o;
  logic [15:0] sr_o;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  addsub_ccr_unit u0 (
    .clk(clk), .rst(rst), .en(en), .op(op), .size(size), .src(src), .dst(dst),
    .dst_is_areg(areg), .sr_in(sr_in), .result_o(result_o), .wr_o(wr_o),
    .upd_o(upd_o), .sr_o(sr_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic        ar;
    logic [31:0] s;
    logic [31:0] d;
    logic [31:0] r;
    logic        w;
    logic        u;
    logic [3:0]  cc;   // N Z V C
  } vec_t;

  localparam logic [15:0] SRIN = 16'h2705;
  localparam int NV = 14;
  // op: 0 add 1 sub 2 cmp 3 neg
  localparam vec_t VEC [NV] = '{
    {2'd0,2'd0,1'b0,32'h00000020,32'h123456F0,32'h12345610,1'b1,1'b1,4'b0001}, // R2 R8
    {2'd0,2'd0,1'b0,32'h00000001,32'hAAAAAA7F,32'hAAAAAA80,1'b1,1'b1,4'b1010}, // R3 R1
    {2'd0,2'd1,1'b0,32'h00000001,32'h0001FFFF,32'h00010000,1'b1,1'b1,4'b0101}, // R2
    {2'd0,2'd2,1'b0,32'h80000000,32'h80000000,32'h00000000,1'b1,1'b1,4'b0111}, // R3
    {2'd1,2'd1,1'b0,32'h00000007,32'h00000005,32'h0000FFFE,1'b1,1'b1,4'b1001}, // R2 R4
    {2'd1,2'd0,1'b0,32'h00000001,32'h11111180,32'h1111117F,1'b1,1'b1,4'b0010}, // R3
    {2'd1,2'd2,1'b1,32'h00000010,32'h00001000,32'h00000FF0,1'b1,1'b0,4'b0000}, // R5
    {2'd0,2'd2,1'b1,32'h00000001,32'hFFFFFFFF,32'h00000000,1'b1,1'b0,4'b0000}, // R5
    {2'd2,2'd1,1'b1,32'h00000003,32'h00000003,32'h00000000,1'b0,1'b1,4'b0100}, // R6
    {2'd2,2'd0,1'b0,32'h00000020,32'h00000010,32'h00000000,1'b0,1'b1,4'b1001}, // R6
    {2'd3,2'd0,1'b0,32'h00000000,32'hFFFFFF01,32'hFFFFFFFF,1'b1,1'b1,4'b1001}, // R7
    {2'd3,2'd1,1'b0,32'h00000000,32'h12340000,32'h12340000,1'b1,1'b1,4'b0100}, // R7
    {2'd3,2'd2,1'b0,32'h00000000,32'h80000000,32'h80000000,1'b1,1'b1,4'b1011}, // R7
    {2'd0,2'd3,1'b0,32'h00000001,32'hFFFFFFFF,32'h00000000,1'b1,1'b1,4'b0101}  // R1
  };

  task automatic check(input string req, input logic [31:0] r, input logic w,
                       input logic u, input logic [15:0] s);
    total++;
    if (result_o !== r || wr_o !== w || upd_o !== u || sr_o !== s) begin
      bad++;
      $display("FAIL %s: got res=%h wr=%b upd=%b sr=%h exp res=%h wr=%b upd=%b sr=%h",
               req, result_o, wr_o, upd_o, sr_o, r, w, u, s);
    end
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; op = 2'd0; size = 2'd0; areg = 1'b0;
    src = '0; dst = '0; sr_in = SRIN;
    repeat (3) @(negedge clk);
    check("R11 reset", 32'h0, 1'b0, 1'b0, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      en = 1'b1; op = v.op; size = v.sz; areg = v.ar; src = v.s; dst = v.d;
      sr_in = SRIN;
      @(negedge clk);
      check($sformatf("R1-table vec%0d", i), v.r, v.w, v.u,
            v.u ? {SRIN[15:4], v.cc} : SRIN);
    end

    // R10 idle cycle: strobes drop, result and status hold
    en = 1'b0; sr_in = 16'hFFFF; dst = 32'h55555555; op = 2'd3;
    @(negedge clk);
    check("R10 idle hold", 32'h0, 1'b0, 1'b0, 16'h2705);

    // R9 busy upper status bits are kept; 1+1 byte clears all flags
    en = 1'b1; op = 2'd0; size = 2'd0; areg = 1'b0;
    src = 32'h1; dst = 32'hCAFE0001; sr_in = 16'hBEEA;
    @(negedge clk);
    check("R9 upper bits", 32'hCAFE0002, 1'b1, 1'b1, 16'hBEE0);

    // R8 word carry without overflow: 0xFFFF + 0x0002
    op = 2'd0; size = 2'd1; src = 32'h2; dst = 32'h0000FFFF; sr_in = 16'h0000;
    @(negedge clk);
    check("R8 carry only", 32'h00000001, 1'b1, 1'b1, 16'h0001);

    // R7 negate of zero: no carry
    op = 2'd3; size = 2'd2; dst = 32'h0;
    @(negedge clk);
    check("R7 neg zero", 32'h0, 1'b1, 1'b1, 16'h0004);

    // R11 reset mid-run
    en = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R11 reset again", 32'h0, 1'b0, 1'b0, 16'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule